// File: doc/BRIEF.md
# Timer and Watchdog with a Shared Assignable Divider

This block combines an 8-bit event timer and a watchdog. The two share one 8-bit divider, and a control bit decides which of them uses it. When the divider is given to the timer, it sits in front of the timer. The timer then advances once every 2, 4, ... 256 source events. When the divider is given to the watchdog, it sits behind the watchdog's base counter. The watchdog then times out once every 1, 2, ... 128 base-counter wraps, and the timer steps on every source event.

The timer counts one of two sources. The first is an instruction-cycle enable. The second is transitions on an external pin, which is synchronized first, on the rising or the falling edge. Software can load the timer value directly. A wrap from 0xFF to 0x00 sets a sticky overflow flag. The watchdog's base counter advances on a time-base tick. A clear input restarts the watchdog. A timeout is reported as a one-cycle pulse.

Top module: `tmr_wdt_shared_div`

## Requirements
- R1: After reset, `tmr_q` is 0, `tmr_ovf` is 0 and `wdt_to` is 0. Every control bit is 1: external source, falling edge, divider given to the watchdog, rate code 7. As a result, the timer steps once per falling edge of `ext_pin`.
- R2: With `ctl_wdata[3]`=0 (divider given to the timer) and rate code n in `ctl_wdata[2:0]`, the timer advances once every 2^(n+1) source events.
- R3: With the divider given to the watchdog, the timer advances on every source event.
- R4: With `ctl_wdata[5]`=0, each cycle in which `cyc_en` is high is one source event. With `ctl_wdata[5]`=1, each qualifying edge of `ext_pin` is exactly one event. The pin passes through two synchronizer flops, so an edge first sampled at clock edge k changes `tmr_q` at edge k+2.
- R5: `ctl_wdata[4]`=1 selects high-to-low transitions on `ext_pin`. `ctl_wdata[4]`=0 selects low-to-high transitions.
- R6: `tmr_ovf` is set when the timer advances from 0xFF to 0x00. It stays set until a cycle with `ovf_clr` high and no new wrap. A wrap in the same cycle as `ovf_clr` wins.
- R7: `tmr_we` loads `tmr_wdata` into the timer on the next edge, overriding any advance in that cycle. When the divider is given to the timer, the write also clears the divider count.
- R8: A `WDW`-bit base counter counts `wdt_tick`. With the divider given to the watchdog and rate code n, `wdt_to` pulses high for one cycle after every 2^n-th base wrap. With the divider given to the timer, it pulses after every base wrap.
- R9: `wdt_clr` resets the base counter, and also the divider count when the divider is given to the watchdog. A tick in the same cycle is discarded, so no timeout follows it.
- R10: `ctl_we` writes the control register from `ctl_wdata` as follows: bit 5 selects the source, bit 4 selects the edge, bit 3 selects the assignment, and bits 2:0 hold the rate code. The new settings take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | Instruction-cycle enable (internal source) |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_tick | input | 1 | Watchdog time-base tick |
| wdt_clr | input | 1 | Watchdog restart |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control write data {source, edge, assign, rate[2:0]} |
| tmr_we | input | 1 | Timer load strobe |
| tmr_wdata | input | TW | Timer load value |
| ovf_clr | input | 1 | Clears the overflow flag |
| tmr_q | output | TW | Timer value |
| tmr_ovf | output | 1 | Sticky overflow flag |
| wdt_to | output | 1 | One-cycle watchdog timeout pulse |

## Verification
The hardest cases to reach are the ones where the divider count already has a partial value when a timer load or a watchdog clear arrives. Whether the divider is cleared depends on which side holds it, so the same stimulus gives different results on each side. A timeout at a ratio above 1:1 also needs several full base-counter wraps before it can be seen. Directed sequences handle both: they advance the divider to a known partial count and then load or clear, and they hold the tick high through complete base wraps. Long constrained-random runs follow, with occasional control rewrites, so that the assignment changes while counts are already partial.

// File: rtl/tmr_wdt_shared_div.sv
module tmr_wdt_shared_div #(
  parameter int TW  = 8,
  parameter int WDW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_en,
  input  logic          ext_pin,
  input  logic          wdt_tick,
  input  logic          wdt_clr,
  input  logic          ctl_we,
  input  logic [5:0]    ctl_wdata,
  input  logic          tmr_we,
  input  logic [TW-1:0] tmr_wdata,
  input  logic          ovf_clr,
  output logic [TW-1:0] tmr_q,
  output logic          tmr_ovf,
  output logic          wdt_to
);
  localparam int PW = 8;

  logic [2:0]     sync_q;
  logic [5:0]     ctl_q;
  logic [PW-1:0]  pre_q;
  logic [WDW-1:0] wb_q;

  wire       src_sel = ctl_q[5];
  wire       edge_sel = ctl_q[4];
  wire       to_wdt  = ctl_q[3];
  wire [2:0] rate    = ctl_q[2:0];

  wire rise    = sync_q[1] & ~sync_q[2];
  wire fall    = ~sync_q[1] & sync_q[2];
  wire src_evt = src_sel ? (edge_sel ? fall : rise) : cyc_en;

  wire [PW-1:0] tmask = PW'((9'd2 << rate) - 9'd1);
  wire [PW-1:0] wmask = PW'((9'd1 << rate) - 9'd1);

  wire tmr_inc  = src_evt & (to_wdt | ((pre_q & tmask) == tmask));
  wire base_ovf = wdt_tick & ~wdt_clr & (&wb_q);
  wire to_hit   = base_ovf & (~to_wdt | ((pre_q & wmask) == wmask));
  wire pre_clr  = to_wdt ? wdt_clr : tmr_we;
  wire pre_adv  = to_wdt ? base_ovf : src_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '0;
      ctl_q   <= '1;
      pre_q   <= '0;
      wb_q    <= '0;
      tmr_q   <= '0;
      tmr_ovf <= 1'b0;
      wdt_to  <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], ext_pin};
      if (ctl_we) ctl_q <= ctl_wdata;

      if (pre_clr)      pre_q <= '0;
      else if (pre_adv) pre_q <= pre_q + 1'b1;

      if (wdt_clr)       wb_q <= '0;
      else if (wdt_tick) wb_q <= wb_q + 1'b1;

      if (tmr_we)       tmr_q <= tmr_wdata;
      else if (tmr_inc) tmr_q <= tmr_q + 1'b1;

      if (tmr_inc & ~tmr_we & (&tmr_q)) tmr_ovf <= 1'b1;
      else if (ovf_clr)                 tmr_ovf <= 1'b0;

      wdt_to <= to_hit;
    end
  end
endmodule

// File: rtl/tmr_wdt_shared_div_chk.sv
module tmr_wdt_shared_div_chk #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tmr_we,
  input logic [TW-1:0] tmr_wdata,
  input logic          ovf_clr,
  input logic          wdt_clr,
  input logic [TW-1:0] tmr_q,
  input logic          tmr_ovf,
  input logic          wdt_to
);
  AST_TO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wdt_to |=> !wdt_to); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (tmr_ovf && !ovf_clr) |=> tmr_ovf); // R6
  AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n) tmr_we |=> tmr_q == $past(tmr_wdata)); // R7
  AST_CLR_NO_TO: assert property (@(posedge clk) disable iff (!rst_n) wdt_clr |=> !wdt_to); // R9
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_we |=> (tmr_q == $past(tmr_q) || tmr_q == TW'($past(tmr_q) + 1'b1))); // R2
endmodule

bind tmr_wdt_shared_div tmr_wdt_shared_div_chk #(.TW(TW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tmr_we(tmr_we), .tmr_wdata(tmr_wdata),
  .ovf_clr(ovf_clr), .wdt_clr(wdt_clr), .tmr_q(tmr_q), .tmr_ovf(tmr_ovf),
  .wdt_to(wdt_to)
);

// File: tb/tmr_wdt_shared_div_tb_top.sv
module tmr_wdt_shared_div_tb_top;
  localparam int WDW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_en = 0, ext_pin = 0, wdt_tick = 0, wdt_clr = 0, ctl_we = 0, tmr_we = 0, ovf_clr = 0;
  logic [5:0] ctl_wdata = '0;
  logic [7:0] tmr_wdata = '0;
  logic [7:0] tmr_q;
  logic tmr_ovf, wdt_to;

  int vec_cnt = 0, bad_cnt = 0, cyc_cnt = 0;

  bit m_s1, m_s2, m_s3, m_ovf, m_to;
  logic [5:0] m_ctl;
  int m_pre, m_wb, m_tmr;

  always #2 clk = ~clk;

  tmr_wdt_shared_div #(.TW(8), .WDW(WDW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin), .wdt_tick(wdt_tick),
    .wdt_clr(wdt_clr), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .tmr_we(tmr_we),
    .tmr_wdata(tmr_wdata), .ovf_clr(ovf_clr), .tmr_q(tmr_q), .tmr_ovf(tmr_ovf), .wdt_to(wdt_to)
  );

  always @(posedge clk) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt > 150000) begin
      bad_cnt = bad_cnt + 1;
      $display("FAIL watchdog expired: act=%0d cycles exp<=150000", cyc_cnt);
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
      $finish;
    end
  end

  function automatic int ratio_tmr(input logic [2:0] r); return 2 << r; endfunction
  function automatic int ratio_wdt(input logic [2:0] r); return 1 << r; endfunction

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_s3 = 0; m_ovf = 0; m_to = 0;
    m_ctl = '1; m_pre = 0; m_wb = 0; m_tmr = 0;
  endtask

  task automatic model_step();
    bit ev, inc, bo, hit;
    int rt, rw;
    ev  = m_ctl[5] ? (m_ctl[4] ? (!m_s2 && m_s3) : (m_s2 && !m_s3)) : cyc_en;
    rt  = ratio_tmr(m_ctl[2:0]);
    rw  = ratio_wdt(m_ctl[2:0]);
    inc = ev && (m_ctl[3] || (m_pre % rt) == rt - 1);
    bo  = wdt_tick && !wdt_clr && (m_wb == (1 << WDW) - 1);
    hit = bo && (!m_ctl[3] || (m_pre % rw) == rw - 1);
    if ((m_ctl[3] && wdt_clr) || (!m_ctl[3] && tmr_we)) m_pre = 0;
    else if (m_ctl[3] ? bo : ev) m_pre = (m_pre + 1) % 256;
    if (wdt_clr) m_wb = 0;
    else if (wdt_tick) m_wb = (m_wb + 1) % (1 << WDW);
    if (inc && !tmr_we && m_tmr == 255) m_ovf = 1;
    else if (ovf_clr) m_ovf = 0;
    if (tmr_we) m_tmr = tmr_wdata;
    else if (inc) m_tmr = (m_tmr + 1) % 256;
    m_to = hit;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
    if (ctl_we) m_ctl = ctl_wdata;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    vec_cnt++;
    if (act != exp) begin
      bad_cnt++;
      $display("FAIL %s: act=%0d exp=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk({tag, " tmr_q"}, int'(tmr_q), m_tmr);
    chk({tag, " tmr_ovf"}, int'(tmr_ovf), int'(m_ovf));
    chk({tag, " wdt_to"}, int'(wdt_to), int'(m_to));
  endtask

  task automatic quiet();
    cyc_en = 0; wdt_tick = 0; wdt_clr = 0; ctl_we = 0; tmr_we = 0; ovf_clr = 0;
  endtask

  task automatic setctl(input string tag, input logic [5:0] v);
    ctl_we = 1; ctl_wdata = v; cyc(tag); ctl_we = 0;
  endtask

  task automatic load(input string tag, input logic [7:0] v);
    tmr_we = 1; tmr_wdata = v; cyc(tag); tmr_we = 0;
  endtask

  task automatic pin_edges(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      ext_pin = ~ext_pin; cyc(tag); cyc(tag); cyc(tag);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset tmr_q", int'(tmr_q), 0);
    chk("R1 reset tmr_ovf", int'(tmr_ovf), 0);
    chk("R1 reset wdt_to", int'(wdt_to), 0);

    // R1: reset defaults count falling pin edges 1:1
    pin_edges("R1", 8);
    chk("R1 falling edges counted", int'(tmr_q), 4);

    // R4 internal source, R3 divider with watchdog
    setctl("R10", 6'b001_111);
    for (int i = 0; i < 40; i++) begin cyc_en = (i % 3 != 0); cyc("R4"); end
    cyc_en = 0;
    load("R7", 8'h00);
    for (int i = 0; i < 10; i++) begin cyc_en = 1; cyc("R3"); end
    cyc_en = 0;
    chk("R3 1:1 count", int'(tmr_q), 10);

    // R2 every rate on the timer side
    for (int r = 0; r < 8; r++) begin
      setctl("R10", {3'b000, 3'(r)});
      load("R7", 8'h00);
      cyc_en = 1;
      for (int i = 0; i < (2 << r) * 3; i++) cyc("R2");
      cyc_en = 0;
      chk("R2 divided count", int'(tmr_q), 3);
    end

    // R5 rising vs falling edge with sync latency
    setctl("R10", 6'b101_111);
    load("R7", 8'h00);
    pin_edges("R5", 6);
    chk("R5 rising edges", int'(tmr_q), 3);
    setctl("R10", 6'b111_111);
    pin_edges("R5", 6);
    chk("R5 falling edges", int'(tmr_q), 6);
    ext_pin = ~ext_pin; cyc("R4"); cyc("R4");
    chk("R4 no change one edge after sample", int'(tmr_q), 6);
    cyc("R4");
    chk("R4 change two edges after sample", int'(tmr_q), ext_pin ? 6 : 7);

    // R6 overflow sticky and set-over-clear
    setctl("R10", 6'b001_000);
    load("R6", 8'hFF);
    cyc_en = 1; cyc("R6"); cyc_en = 0;
    chk("R6 wrap value", int'(tmr_q), 0);
    chk("R6 flag set", int'(tmr_ovf), 1);
    repeat (5) cyc("R6");
    chk("R6 flag holds", int'(tmr_ovf), 1);
    ovf_clr = 1; cyc("R6"); ovf_clr = 0;
    chk("R6 flag cleared", int'(tmr_ovf), 0);
    load("R6", 8'hFF);
    cyc_en = 1; ovf_clr = 1; cyc("R6"); cyc_en = 0; ovf_clr = 0;
    chk("R6 wrap beats clear", int'(tmr_ovf), 1);

    // R7 load clears the divider on the timer side (1:4)
    setctl("R10", 6'b000_001);
    load("R7", 8'h00);
    cyc_en = 1; repeat (3) cyc("R7"); cyc_en = 0;
    load("R7", 8'h10);
    cyc_en = 1; repeat (3) cyc("R7");
    chk("R7 divider cleared", int'(tmr_q), 16);
    cyc("R7"); cyc_en = 0;
    chk("R7 advance after four", int'(tmr_q), 17);
    cyc_en = 1; tmr_we = 1; tmr_wdata = 8'h40; cyc("R7"); tmr_we = 0; cyc_en = 0;
    chk("R7 load beats advance", int'(tmr_q), 64);

    // R8 watchdog 1:1 and 1:4
    setctl("R10", 6'b001_000);
    wdt_clr = 1; cyc("R9"); wdt_clr = 0;
    wdt_tick = 1;
    repeat (15) cyc("R8");
    chk("R8 no early timeout", int'(wdt_to), 0);
    cyc("R8");
    chk("R8 timeout pulse", int'(wdt_to), 1);
    cyc("R8");
    chk("R8 pulse one cycle", int'(wdt_to), 0);
    setctl("R10", 6'b001_010);
    wdt_clr = 1; cyc("R9"); wdt_clr = 0;
    for (int i = 0; i < 16 * 9; i++) cyc("R8");
    // R9 clear at the wrapping tick discards it
    wdt_clr = 1; cyc("R9"); wdt_clr = 0;
    repeat (15) cyc("R9");
    wdt_clr = 1; cyc("R9"); wdt_clr = 0;
    cyc("R9");
    chk("R9 no timeout after clear", int'(wdt_to), 0);
    wdt_tick = 0;
    setctl("R10", 6'b000_000);
    wdt_tick = 1; for (int i = 0; i < 40; i++) cyc("R8"); wdt_tick = 0;

    // Random phase
    for (int i = 0; i < 20000; i++) begin
      cyc_en   = 1'($urandom);
      wdt_tick = ($urandom % 4) != 0;
      wdt_clr  = ($urandom % 97) == 0;
      ovf_clr  = ($urandom % 53) == 0;
      tmr_we   = ($urandom % 211) == 0;
      tmr_wdata = 8'($urandom);
      ctl_we   = ($urandom % 499) == 0;
      ctl_wdata = {1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom % 4)};
      if (($urandom % 3) == 0) ext_pin = ~ext_pin;
      cyc(ctl_we ? "R10" : (m_ctl[3] ? "R3" : "R2"));
    end
    quiet();
    cyc("R10");

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end
endmodule